// File: doc/BRIEF.md
# Multiple-Bus Grant Allocator

This block is the bus stage of a two-stage arbitration scheme for a shared-memory system with several processors, several memory modules and fewer buses than modules. Each memory module has its own arbiter, upstream and outside this block, that picks one requesting processor per cycle. This block receives those per-module winners and hands out the buses. It serves at most one winner per bus in the same cycle and uses a fixed priority in which a lower module index wins.

Bus 0 carries the lowest-indexed winning module. Bus 1 carries the next one, and so on until either the buses or the winners run out. Each occupied bus reports the processor ID and the module index it serves. A per-module "granted" vector tells the first stage which winners actually got a bus. A processor's transfer goes ahead only when it holds both its module grant and a bus grant. Winners left without a bus must resubmit in the next memory cycle.

All outputs are registered. Every cycle's grants are computed afresh from that cycle's winners, and nothing carries over from one cycle to the next.

Top module: `mbus_grant_alloc`

## Requirements
- R1: While `rst_n` is low, and after the first clock edge under reset, every output is zero.
- R2: Outputs are registered. Winners sampled at clock edge k appear on the outputs after edge k and stay unchanged until edge k+1.
- R3: Bus j (j counted from 0) is valid exactly when at least j+1 module winners were sampled. It then serves the (j+1)-th lowest set bit of `win_vld`, so priority is by ascending module index.
- R4: The number of set bits in `mem_granted` is never above NUM_BUS and always equals the number of set bits in `bus_vld`.
- R5: With fewer winners than buses, the valid buses form a contiguous group starting at bus 0. Each unused bus has valid low and its `bus_pid` and `bus_mem` fields zero.
- R6: With more winners than buses, only the NUM_BUS lowest-indexed winners get a `mem_granted` bit. Every higher-indexed winner's bit is 0, which tells it to resubmit.
- R7: On a valid bus j, `bus_mem[j]` holds the binary module index served. `bus_pid[j]` holds that module's processor ID, taken from field `win_pid[idx*PID_W +: PID_W]`.
- R8: A cycle with no winners yields all-zero outputs in the next cycle. No grant from an earlier cycle survives.
- R9: A `mem_granted` bit is set only for a module whose `win_vld` bit was set at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_vld | input | NUM_MEM | One bit per memory module: that module's arbiter has a winner this cycle |
| win_pid | input | NUM_MEM*PID_W | Processor ID of each module's winner, field i belongs to module i |
| bus_vld | output | NUM_BUS | Bus j carries a granted transfer |
| bus_pid | output | NUM_BUS*PID_W | Processor ID served on each bus, field j belongs to bus j |
| bus_mem | output | NUM_BUS*MIDX_W | Memory-module index served on each bus, MIDX_W = clog2(NUM_MEM) |
| mem_granted | output | NUM_MEM | Per-module flag: that module's winner received a bus |

## Verification
Every result of this block is due one clock edge after the winners are sampled. The bench drives inputs on the falling edge. It first confirms that the outputs still show the previous cycle's grants, which tests the register boundary of R2. It then waits one rising edge and samples all outputs at the next falling edge. The scenarios cover:
- no winners;
- one winner;
- fewer winners than buses;
- exactly as many winners as buses, placed at high indices;
- more winners than buses;
- a full vector followed by an empty one, which shows that nothing carries over.

// File: rtl/mbga_pkg.sv
package mbga_pkg;
    localparam int DEF_NUM_MEM = 16;
    localparam int DEF_NUM_BUS = 4;
    localparam int DEF_PID_W   = 4;

    function automatic int idx_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/mbga_lsb_pick.sv
module mbga_lsb_pick #(
    parameter int W  = 16,
    localparam int IW = mbga_pkg::idx_width(W)
) (
    input  logic [W-1:0]  req,
    output logic [W-1:0]  pick_oh,
    output logic [IW-1:0] pick_idx,
    output logic          found
);
    always_comb begin
        pick_idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) pick_idx = IW'(i);
        end
    end

    assign pick_oh = req & (~req + W'(1));
    assign found   = |req;
endmodule

// File: rtl/mbga_pid_mux.sv
module mbga_pid_mux #(
    parameter int N  = 16,
    parameter int PW = 4,
    localparam int IW = mbga_pkg::idx_width(N)
) (
    input  logic [N*PW-1:0] pid_flat,
    input  logic [IW-1:0]   sel,
    output logic [PW-1:0]   pid
);
    always_comb begin
        pid = '0;
        for (int i = 0; i < N; i++) begin
            if (sel == IW'(i)) pid = pid_flat[i*PW +: PW];
        end
    end
endmodule

// File: rtl/mbus_grant_alloc.sv
module mbus_grant_alloc #(
    parameter int NUM_MEM = mbga_pkg::DEF_NUM_MEM,
    parameter int NUM_BUS = mbga_pkg::DEF_NUM_BUS,
    parameter int PID_W   = mbga_pkg::DEF_PID_W,
    localparam int MIDX_W = mbga_pkg::idx_width(NUM_MEM)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_MEM-1:0]        win_vld,
    input  logic [NUM_MEM*PID_W-1:0]  win_pid,
    output logic [NUM_BUS-1:0]        bus_vld,
    output logic [NUM_BUS*PID_W-1:0]  bus_pid,
    output logic [NUM_BUS*MIDX_W-1:0] bus_mem,
    output logic [NUM_MEM-1:0]        mem_granted
);
    typedef struct packed {
        logic [NUM_BUS-1:0]             vld;
        logic [NUM_BUS-1:0][PID_W-1:0]  pid;
        logic [NUM_BUS-1:0][MIDX_W-1:0] mem;
        logic [NUM_MEM-1:0]             granted;
    } alloc_t;

    alloc_t st_d, st_q;

    // Candidates still unserved before each bus slot
    logic [NUM_BUS:0][NUM_MEM-1:0]  remain;
    logic [NUM_BUS-1:0][NUM_MEM-1:0] slot_oh;
    logic [NUM_BUS-1:0][MIDX_W-1:0]  slot_idx;
    logic [NUM_BUS-1:0][PID_W-1:0]   slot_pid;
    logic [NUM_BUS-1:0]              slot_found;

    assign remain[0] = win_vld;

    for (genvar j = 0; j < NUM_BUS; j++) begin : g_slot
        mbga_lsb_pick #(.W(NUM_MEM)) pick_i (
            .req      (remain[j]),
            .pick_oh  (slot_oh[j]),
            .pick_idx (slot_idx[j]),
            .found    (slot_found[j])
        );

        mbga_pid_mux #(.N(NUM_MEM), .PW(PID_W)) mux_i (
            .pid_flat (win_pid),
            .sel      (slot_idx[j]),
            .pid      (slot_pid[j])
        );

        assign remain[j+1] = remain[j] & ~slot_oh[j];
    end

    always_comb begin
        st_d = '0;
        for (int j = 0; j < NUM_BUS; j++) begin
            st_d.vld[j] = slot_found[j];
            if (slot_found[j]) begin
                st_d.pid[j]  = slot_pid[j];
                st_d.mem[j]  = slot_idx[j];
                st_d.granted = st_d.granted | slot_oh[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_vld     = st_q.vld;
    assign mem_granted = st_q.granted;

    for (genvar j = 0; j < NUM_BUS; j++) begin : g_out
        assign bus_pid[j*PID_W +: PID_W]   = st_q.pid[j];
        assign bus_mem[j*MIDX_W +: MIDX_W] = st_q.mem[j];
    end
endmodule

// File: rtl/mbga_chk.sv
module mbga_chk #(
    parameter int NUM_MEM = 16,
    parameter int NUM_BUS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_MEM-1:0] win_vld,
    input logic [NUM_BUS-1:0] bus_vld,
    input logic [NUM_MEM-1:0] mem_granted
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_GRANT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mem_granted) <= NUM_BUS); // R4
    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mem_granted) == $countones(bus_vld)); // R4
    AST_CONTIG_BUSES: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_vld + 1'b1) & bus_vld) == '0); // R5
    AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && win_vld == '0) |=> (bus_vld == '0 && mem_granted == '0)); // R8
    AST_FULL_USE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $countones(win_vld) >= NUM_BUS) |=> (&bus_vld)); // R6
    AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |=> ((mem_granted & ~$past(win_vld)) == '0)); // R9
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (bus_vld == '0 && mem_granted == '0)); // R1
endmodule

bind mbus_grant_alloc mbga_chk #(.NUM_MEM(NUM_MEM), .NUM_BUS(NUM_BUS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .win_vld     (win_vld),
    .bus_vld     (bus_vld),
    .mem_granted (mem_granted)
);

// File: tb/mbus_grant_alloc_tb_top.sv
`timescale 1ns/1ps
module mbus_grant_alloc_tb_top;
    localparam int NM = 16;
    localparam int NB = 4;
    localparam int PW = 4;
    localparam int MW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NM-1:0]     win_vld = '0;
    logic [NM*PW-1:0]  win_pid = '0;
    logic [NB-1:0]     bus_vld;
    logic [NB*PW-1:0]  bus_pid;
    logic [NB*MW-1:0]  bus_mem;
    logic [NM-1:0]     mem_granted;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [NB-1:0] prev_vld = '0;
    logic [NM-1:0] prev_gnt = '0;

    always #10 clk = ~clk;

    mbus_grant_alloc #(.NUM_MEM(NM), .NUM_BUS(NB), .PID_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .win_pid(win_pid),
        .bus_vld(bus_vld), .bus_pid(bus_pid), .bus_mem(bus_mem),
        .mem_granted(mem_granted)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drives one winner vector and checks the registered result
    task automatic run_case(input logic [NM-1:0] v, input int seed, input string req);
        logic [NB-1:0] e_vld = '0;
        logic [NM-1:0] e_gnt = '0;
        logic [PW-1:0] e_pid [NB];
        logic [MW-1:0] e_mem [NB];
        int k = 0;
        for (int b = 0; b < NB; b++) begin e_pid[b] = '0; e_mem[b] = '0; end
        @(negedge clk);
        win_vld = v;
        for (int i = 0; i < NM; i++) begin
            win_pid[i*PW +: PW] = PW'((i * 7 + seed) % 16);
            if (v[i] && k < NB) begin
                e_vld[k] = 1'b1; e_gnt[i] = 1'b1;
                e_pid[k] = PW'((i * 7 + seed) % 16);
                e_mem[k] = MW'(i);
                k++;
            end
        end
        #2;
        // R2: nothing changes before the next rising edge
        chk("R2", "bus_vld before edge", 64'(bus_vld), 64'(prev_vld));
        chk("R2", "mem_granted before edge", 64'(mem_granted), 64'(prev_gnt));
        @(posedge clk);
        @(negedge clk);
        chk(req, "bus_vld", 64'(bus_vld), 64'(e_vld));
        chk(req, "mem_granted", 64'(mem_granted), 64'(e_gnt));
        for (int b = 0; b < NB; b++) begin
            chk(req, $sformatf("bus_pid[%0d] (R7)", b), 64'(bus_pid[b*PW +: PW]), 64'(e_pid[b]));
            chk(req, $sformatf("bus_mem[%0d] (R7)", b), 64'(bus_mem[b*MW +: MW]), 64'(e_mem[b]));
        end
        prev_vld = e_vld;
        prev_gnt = e_gnt;
    endtask

    task automatic t_reset();
        win_vld = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs zero under reset
        chk("R1", "bus_vld in reset", 64'(bus_vld), 64'h0);
        chk("R1", "mem_granted in reset", 64'(mem_granted), 64'h0);
        chk("R1", "bus_pid in reset", 64'(bus_pid), 64'h0);
        chk("R1", "bus_mem in reset", 64'(bus_mem), 64'h0);
        win_vld = '0;
        rst_n = 1'b1;
    endtask

    task automatic t_single();   run_case(16'h0200, 3, "R3");  endtask // one winner at module 9
    task automatic t_few();      run_case(16'h8011, 5, "R5");  endtask // three winners, bus 3 unused
    task automatic t_exact();    run_case(16'hF000, 1, "R3");  endtask // four winners at top indices
    task automatic t_overflow(); run_case(16'hFFFF, 9, "R6");  endtask // 16 winners, 4 buses (R4)
    task automatic t_sparse();   run_case(16'hA5A5, 2, "R4");  endtask // 8 winners, 4 lowest served
    task automatic t_empty();    run_case(16'h0000, 0, "R8");  endtask // no carryover (R9)

    initial begin
        t_reset();
        t_single();
        t_few();
        t_exact();
        t_overflow();
        t_empty();
        t_sparse();
        t_few();
        t_empty();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule